// File: doc/BRIEF.md
# Burst Spike Scheduler

The scheduler sits between the spiking neurons of an event-driven neural core and the controller that turns each spike into synaptic updates. Neurons hand it event packets. A packet names its source neuron and asks for either a single spike or a burst of evenly spaced spikes. The scheduler releases the spikes one address at a time on a valid/ready output, in priority order.

Single spikes go into a deep first-in first-out queue that always wins arbitration. A burst is unrolled into its individual spikes, one per cycle. Each spike is written into a ring of small queues, and each queue in the ring stands for one future timestep. A local tick counter with a programmable period moves the "current" marker around the ring, which spaces the burst spikes by the requested number of timesteps. The last spike of every burst carries a flag. When that spike leaves, the scheduler pulses an end-of-burst strobe with the neuron address, so the neuron can be released from its post-burst lock.

Top module: `burst_spike_scheduler`

## Requirements
- R1: An input packet is {address[13:6], count[5:3], interval[2:0]}. A packet whose count field is 0 is a single spike. Single spikes leave on out_addr in the order they arrived.
- R2: While the single-spike queue holds anything, its head is offered on the output ahead of any burst spike.
- R3: A burst packet with count field c and interval field i yields c+1 spikes. Spike k is due k·(i+1) timesteps after spike 0, so consecutive spikes that are released on time leave (i+1)·(tick_period+1) cycles apart.
- R4: A timestep tick occurs once every tick_period+1 clock cycles.
- R5: Accepting a burst of n spikes drops in_ready for exactly the n following cycles while the spikes are written.
- R6: burst_end is high exactly in the cycle in which the last spike of a burst is handed over (out_valid and out_ready both high). burst_end_addr then equals out_addr.
- R7: Each timestep queue holds 4 entries. A burst spike aimed at a full queue is dropped, and slot_overflow is set and stays set until reset.
- R8: A timestep queue that is not empty when a tick arrives keeps its entries. The missed ticks are remembered. The ring advances only once the current queue is empty, so held entries leave before later timesteps, each queue in arrival order.
- R9: After reset, out_valid, burst_end and slot_overflow are low, and in_ready is high.
- R10: Once out_valid is high, it stays high until a handshake takes place.
- R11: The single-spike queue holds 32 entries. When it is full, in_ready is low for a single-spike packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Packet accepted this cycle when high together with in_valid |
| in_pkt | input | 14 | Address, count-minus-one and interval fields |
| tick_period | input | 16 | Tick spacing minus one, in cycles |
| out_valid | output | 1 | Spike address available |
| out_ready | input | 1 | Controller takes the spike |
| out_addr | output | 8 | Source neuron of the offered spike |
| burst_end | output | 1 | Last spike of a burst handed over this cycle |
| burst_end_addr | output | 8 | Neuron whose burst has ended |
| slot_overflow | output | 1 | Sticky: a burst spike was dropped |

## Verification
The checker watches four properties on every cycle. out_valid is held until a handshake. burst_end appears only on a handshake and carries the offered address. The overflow flag is sticky. Taking a burst packet stalls the input on the next cycle. The bench scenarios are needed for everything that depends on history. They cover the spacing of burst spikes for several interval and tick-period settings, the ordering of single spikes against burst spikes, and the holding of an undrained timestep across many ticks. They also cover the spikes lost when a timestep queue fills, and input backpressure when the single-spike queue is full.

// File: rtl/sched_pkg.sv
package sched_pkg;
   // Number of timestep queues needed for the longest burst with the widest interval.
   function automatic int ring_slots(input int cnt_w, input int isi_w);
      return (2 ** isi_w) * ((2 ** cnt_w) - 1) + 1;
   endfunction
endpackage

// File: rtl/sched_fifo.sv
module sched_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sched_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("sched_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] fill;
   logic             do_push, do_pop;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (fill == '0);
   assign full    = (fill == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= step(wr_ptr);
         if (do_pop)  rd_ptr <= step(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/burst_expander.sv
module burst_expander #(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 3,
   parameter int ISI_W  = 3,
   parameter int SLOT_W = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic [ADDR_W+CNT_W+ISI_W-1:0]   in_pkt,
   input  logic                            ss_full,
   output logic                            in_ready,
   output logic                            ss_push,
   output logic                            busy,
   output logic                            wr_en,
   output logic [SLOT_W-1:0]               wr_off,
   output logic [ADDR_W:0]                 wr_data,
   input  logic                            wr_full,
   output logic                            overflow
);
   localparam int PKT_W  = ADDR_W + CNT_W + ISI_W;
   localparam int STEP_W = ISI_W + 1;

   generate
      if (SLOT_W < STEP_W + CNT_W - 1) begin : g_bad_slot_w
         $error("burst_expander: SLOT_W too narrow for the largest offset");
      end
   endgenerate

   logic [ADDR_W-1:0] pkt_addr;
   logic [CNT_W-1:0]  pkt_cnt;
   logic [ISI_W-1:0]  pkt_isi;
   logic              is_burst, accept, last;

   logic [ADDR_W-1:0] b_addr;
   logic [CNT_W-1:0]  b_cnt, b_k;
   logic [STEP_W-1:0] b_step;
   logic [SLOT_W-1:0] b_off;

   assign pkt_addr = in_pkt[PKT_W-1 -: ADDR_W];
   assign pkt_cnt  = in_pkt[ISI_W +: CNT_W];
   assign pkt_isi  = in_pkt[ISI_W-1:0];
   assign is_burst = (pkt_cnt != '0);

   assign in_ready = !busy && (is_burst || !ss_full);
   assign accept   = in_valid && in_ready;
   assign ss_push  = accept && !is_burst;

   assign last    = (b_k == b_cnt);
   assign wr_en   = busy;
   assign wr_off  = b_off;
   assign wr_data = {last, b_addr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         b_addr   <= '0;
         b_cnt    <= '0;
         b_k      <= '0;
         b_step   <= '0;
         b_off    <= '0;
         overflow <= 1'b0;
      end else begin
         if (busy) begin
            if (wr_full) overflow <= 1'b1;
            if (last) begin
               busy <= 1'b0;
            end else begin
               b_k   <= b_k + 1'b1;
               b_off <= b_off + SLOT_W'(b_step);
            end
         end else if (accept && is_burst) begin
            busy   <= 1'b1;
            b_addr <= pkt_addr;
            b_cnt  <= pkt_cnt;
            b_k    <= '0;
            b_step <= {1'b0, pkt_isi} + 1'b1;
            b_off  <= '0;
         end
      end
   end
endmodule

// File: rtl/slot_ring.sv
module slot_ring #(
   parameter int ENT_W     = 9,
   parameter int DEPTH     = 4,
   parameter int NUM_SLOTS = 57,
   parameter int PERIOD_W  = 16,
   parameter int PEND_W    = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [PERIOD_W-1:0]          tick_period,
   input  logic                         hold,
   input  logic                         wr_en,
   input  logic [$clog2(NUM_SLOTS)-1:0] wr_off,
   input  logic [ENT_W-1:0]             wr_data,
   output logic                         wr_full,
   input  logic                         pop,
   output logic [ENT_W-1:0]             head,
   output logic                         cur_empty
);
   localparam int SLOT_W = $clog2(NUM_SLOTS);
   localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("slot_ring: at least two slots required");
      end
      if (PEND_W < 1) begin : g_bad_pend
         $error("slot_ring: PEND_W must be positive");
      end
   endgenerate

   logic [PERIOD_W-1:0]  tcnt;
   logic                 tick, rotate;
   logic [PEND_W-1:0]    pend;
   logic [SLOT_W-1:0]    cur;
   logic [SLOT_W:0]      sum, tgt;
   logic [ENT_W-1:0]     slot_q [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] empty_v, full_v;

   // Tick generator and deferred rotation bookkeeping.
   assign tick   = (tcnt >= tick_period);
   assign rotate = (tick || (pend != '0)) && cur_empty && !hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt <= '0;
         pend <= '0;
         cur  <= '0;
      end else begin
         tcnt <= tick ? '0 : tcnt + 1'b1;
         if (tick && !rotate && (pend != PEND_MAX)) pend <= pend + 1'b1;
         else if (!tick && rotate)                  pend <= pend - 1'b1;
         if (rotate) cur <= (cur == SLOT_W'(NUM_SLOTS - 1)) ? '0 : cur + 1'b1;
      end
   end

   // Target slot for a write, modulo the ring size.
   assign sum = {1'b0, cur} + {1'b0, wr_off};
   assign tgt = (sum >= (SLOT_W+1)'(NUM_SLOTS)) ? sum - (SLOT_W+1)'(NUM_SLOTS) : sum;

   genvar s;
   generate
      for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
         sched_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (wr_en && (tgt == (SLOT_W+1)'(s))),
            .din   (wr_data),
            .pop   (pop && (cur == SLOT_W'(s))),
            .dout  (slot_q[s]),
            .empty (empty_v[s]),
            .full  (full_v[s])
         );
      end
   endgenerate

   assign head      = slot_q[cur];
   assign cur_empty = empty_v[cur];
   assign wr_full   = full_v[tgt[SLOT_W-1:0]];
endmodule

// File: rtl/burst_spike_scheduler.sv
module burst_spike_scheduler #(
   parameter int ADDR_W     = 8,
   parameter int CNT_W      = 3,
   parameter int ISI_W      = 3,
   parameter int SS_DEPTH   = 32,
   parameter int SLOT_DEPTH = 4,
   parameter int PERIOD_W   = 16,
   parameter int PEND_W     = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [ADDR_W+CNT_W+ISI_W-1:0] in_pkt,
   input  logic [PERIOD_W-1:0]           tick_period,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [ADDR_W-1:0]             out_addr,
   output logic                          burst_end,
   output logic [ADDR_W-1:0]             burst_end_addr,
   output logic                          slot_overflow
);
   localparam int NUM_SLOTS = sched_pkg::ring_slots(CNT_W, ISI_W);
   localparam int SLOT_W    = $clog2(NUM_SLOTS);
   localparam int ENT_W     = ADDR_W + 1;

   generate
      if (ADDR_W < 1 || CNT_W < 1 || ISI_W < 1) begin : g_bad_fields
         $error("burst_spike_scheduler: packet fields must be non-empty");
      end
      if (NUM_SLOTS * SLOT_DEPTH * ENT_W > 8192) begin : g_too_big
         $error("burst_spike_scheduler: ring storage exceeds the supported size");
      end
   endgenerate

   logic              ss_push, ss_pop, ss_empty, ss_full;
   logic [ADDR_W-1:0] ss_head;
   logic              dec_busy, wr_en, wr_full;
   logic [SLOT_W-1:0] wr_off;
   logic [ENT_W-1:0]  wr_data, ring_head;
   logic              ring_empty, ring_pop, handshake;

   burst_expander #(
      .ADDR_W (ADDR_W), .CNT_W (CNT_W), .ISI_W (ISI_W), .SLOT_W (SLOT_W)
   ) u_expand (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_pkt   (in_pkt),
      .ss_full  (ss_full),
      .in_ready (in_ready),
      .ss_push  (ss_push),
      .busy     (dec_busy),
      .wr_en    (wr_en),
      .wr_off   (wr_off),
      .wr_data  (wr_data),
      .wr_full  (wr_full),
      .overflow (slot_overflow)
   );

   sched_fifo #(.WIDTH(ADDR_W), .DEPTH(SS_DEPTH)) u_single (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (ss_push),
      .din   (in_pkt[ADDR_W+CNT_W+ISI_W-1 -: ADDR_W]),
      .pop   (ss_pop),
      .dout  (ss_head),
      .empty (ss_empty),
      .full  (ss_full)
   );

   slot_ring #(
      .ENT_W (ENT_W), .DEPTH (SLOT_DEPTH), .NUM_SLOTS (NUM_SLOTS),
      .PERIOD_W (PERIOD_W), .PEND_W (PEND_W)
   ) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_period (tick_period),
      .hold        (dec_busy),
      .wr_en       (wr_en),
      .wr_off      (wr_off),
      .wr_data     (wr_data),
      .wr_full     (wr_full),
      .pop         (ring_pop),
      .head        (ring_head),
      .cur_empty   (ring_empty)
   );

   // Strict priority: single spikes first, then the current timestep.
   assign out_valid      = !ss_empty || !ring_empty;
   assign out_addr       = !ss_empty ? ss_head : ring_head[ADDR_W-1:0];
   assign handshake      = out_valid && out_ready;
   assign ss_pop         = handshake && !ss_empty;
   assign ring_pop       = handshake && ss_empty;
   assign burst_end      = ring_pop && ring_head[ADDR_W];
   assign burst_end_addr = ring_head[ADDR_W-1:0];
endmodule

// File: rtl/burst_spike_scheduler_chk.sv
module burst_spike_scheduler_chk #(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [CNT_W-1:0]  pkt_cnt,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_addr,
   input logic              burst_end,
   input logic [ADDR_W-1:0] burst_end_addr,
   input logic              slot_overflow
);
   // R10
   out_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid);

   // R6
   end_on_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_end |-> out_valid && out_ready);

   // R6
   end_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_end |-> burst_end_addr == out_addr);

   // R7
   overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_overflow |=> slot_overflow);

   // R5
   expand_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && (pkt_cnt != '0) |=> !in_ready);
endmodule

bind burst_spike_scheduler burst_spike_scheduler_chk #(
   .ADDR_W (ADDR_W), .CNT_W (CNT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_valid       (in_valid),
   .in_ready       (in_ready),
   .pkt_cnt        (in_pkt[ISI_W +: CNT_W]),
   .out_valid      (out_valid),
   .out_ready      (out_ready),
   .out_addr       (out_addr),
   .burst_end      (burst_end),
   .burst_end_addr (burst_end_addr),
   .slot_overflow  (slot_overflow)
);

// File: tb/burst_spike_scheduler_tb.sv
`timescale 1ns/1ps
module burst_spike_scheduler_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [13:0] in_pkt = '0;
   logic [15:0] tick_period = 16'd9;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_addr;
   logic        burst_end;
   logic [7:0]  burst_end_addr;
   logic        slot_overflow;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int ncol     = 0;
   int got_addr [64];
   int got_end  [64];
   int got_cyc  [64];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   burst_spike_scheduler u_dut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
      .in_pkt (in_pkt), .tick_period (tick_period), .out_valid (out_valid),
      .out_ready (out_ready), .out_addr (out_addr), .burst_end (burst_end),
      .burst_end_addr (burst_end_addr), .slot_overflow (slot_overflow)
   );

   function automatic logic [13:0] mk(input int addr, input int cnt, input int isi);
      return {addr[7:0], cnt[2:0], isi[2:0]};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [13:0] p);
      @(negedge clk);
      in_valid = 1'b1;
      in_pkt   = p;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_pkt   = '0;
   endtask

   task automatic collect(input int n, input int tmo, input string req);
      int waited = 0;
      ncol = 0;
      @(negedge clk);
      out_ready = 1'b1;
      while (ncol < n && waited < tmo) begin
         #1;
         if (out_valid) begin
            got_addr[ncol] = out_addr;
            got_end[ncol]  = burst_end;
            got_cyc[ncol]  = cyc;
            ncol++;
         end
         @(negedge clk);
         waited++;
      end
      out_ready = 1'b0;
      check(ncol == n, req, ncol, n);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R9
   task automatic t_reset;
      idle(1);
      #1;
      check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
      check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
      check(slot_overflow == 1'b0, "R9 overflow", slot_overflow, 0);
      check(burst_end == 1'b0, "R9 burst_end", burst_end, 0);
   endtask

   // R1
   task automatic t_singles;
      send(mk(10, 0, 0));
      send(mk(11, 0, 0));
      send(mk(12, 0, 0));
      collect(3, 50, "R1 count");
      for (int k = 0; k < 3; k++) begin
         check(got_addr[k] == 10 + k, "R1 order", got_addr[k], 10 + k);
         check(got_end[k] == 0, "R1 no burst_end", got_end[k], 0);
      end
   endtask

   // R5
   task automatic t_stall;
      int low = 0;
      send(mk(8'h30, 2, 0));
      #1;
      while (!in_ready && low < 20) begin
         low++;
         @(negedge clk);
         #1;
      end
      check(low == 3, "R5 stall cycles", low, 3);
      collect(3, 200, "R5 drain");
   endtask

   // R3 / R4 / R6
   task automatic t_spacing(input int addr, input int isi, input int per);
      int gap;
      tick_period = 16'(per);
      idle(3);
      send(mk(addr, 3, isi));
      collect(4, 1000, "R3 count");
      for (int k = 0; k < 4; k++)
         check(got_addr[k] == addr, "R3 addr", got_addr[k], addr);
      gap = got_cyc[3] - got_cyc[2];
      check(gap == (isi + 1) * (per + 1), "R3 R4 spike gap", gap, (isi + 1) * (per + 1));
      check(got_end[2] == 0, "R6 not last", got_end[2], 0);
      check(got_end[3] == 1, "R6 last", got_end[3], 1);
   endtask

   // R2 / R10
   task automatic t_priority;
      send(mk(8'h50, 1, 0));
      send(mk(8'h21, 0, 0));
      send(mk(8'h22, 0, 0));
      idle(20);
      #1;
      check(out_valid == 1'b1, "R10 held valid", out_valid, 1);
      collect(4, 300, "R2 count");
      check(got_addr[0] == 8'h21, "R2 first", got_addr[0], 8'h21);
      check(got_addr[1] == 8'h22, "R2 second", got_addr[1], 8'h22);
      check(got_addr[2] == 8'h50, "R2 burst after", got_addr[2], 8'h50);
      check(got_addr[3] == 8'h50, "R2 burst tail", got_addr[3], 8'h50);
      check(got_end[3] == 1, "R6 tail end", got_end[3], 1);
   endtask

   // R8
   task automatic t_hold;
      int exp_a [5] = '{8'h60, 8'h61, 8'h60, 8'h61, 8'h60};
      int exp_e [5] = '{0, 0, 0, 1, 1};
      tick_period = 16'd4;
      send(mk(8'h60, 2, 0));
      send(mk(8'h61, 1, 0));
      idle(200);
      collect(5, 300, "R8 count");
      for (int k = 0; k < 5; k++) begin
         check(got_addr[k] == exp_a[k], "R8 order", got_addr[k], exp_a[k]);
         check(got_end[k] == exp_e[k], "R8 end flag", got_end[k], exp_e[k]);
      end
      idle(100);
   endtask

   // R11
   task automatic t_full;
      for (int k = 0; k < 32; k++) send(mk(k + 100, 0, 0));
      @(negedge clk);
      in_valid = 1'b1;
      in_pkt   = mk(200, 0, 0);
      #1;
      check(in_ready == 1'b0, "R11 full stall", in_ready, 0);
      @(negedge clk);
      in_valid = 1'b0;
      in_pkt   = '0;
      collect(32, 200, "R11 count");
      check(got_addr[0] == 100, "R11 first", got_addr[0], 100);
      check(got_addr[31] == 131, "R11 last", got_addr[31], 131);
      idle(5);
      #1;
      check(out_valid == 1'b0, "R11 rejected not queued", out_valid, 0);
      check(slot_overflow == 1'b0, "R7 clean before", slot_overflow, 0);
   endtask

   // R7
   task automatic t_overflow;
      int ea;
      for (int k = 0; k < 5; k++) send(mk(8'h70 + k, 1, 0));
      idle(2);
      #1;
      check(slot_overflow == 1'b1, "R7 set", slot_overflow, 1);
      collect(8, 400, "R7 count");
      for (int k = 0; k < 8; k++) begin
         ea = 8'h70 + (k % 4);
         check(got_addr[k] == ea, "R7 kept order", got_addr[k], ea);
      end
      check(got_end[7] == 1, "R6 overflow tail end", got_end[7], 1);
      idle(100);
      #1;
      check(out_valid == 1'b0, "R7 dropped gone", out_valid, 0);
      check(slot_overflow == 1'b1, "R7 sticky", slot_overflow, 1);
   endtask

   initial begin
      #400000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_singles();
      t_stall();
      t_spacing(8'h41, 2, 9);
      t_spacing(8'h42, 0, 9);
      t_spacing(8'h43, 1, 4);
      t_priority();
      t_hold();
      t_full();
      t_overflow();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule